// File: doc/BRIEF.md
# Periodic Mantissa Normalizer

This block takes the raw output of a rational adder and puts it into its simplest double-mantissa form. In that form a number is a sign, an exponent and two digit strings: a fixed part, followed by a periodic part that repeats forever. The value is `(-1)^sign * 0.F P P P ... * 2^exp`, where all digits are binary. Both strings are right-aligned in their fields, and each string has an explicit length. When that length is zero, the string is empty.

A normalization run has three steps, one after another:

1. While the last fixed digit equals the last periodic digit, that digit is folded into the period.
2. The shortest true period is found by rotating the period and comparing it with its starting value. An all-zero period is cleared.
3. Leading zero digits are stripped, and the exponent is lowered once for each digit stripped.

The adder accepts unnormalized operands, so a chain of additions can skip this block. A bypass request does this: the fields are returned unchanged one cycle later, and only the final result of a chain has to be normalized. A run starts on a one-cycle `start_i` pulse. Completion is flagged by a one-cycle `done_o`.

Top module: `pmn_top`

## Requirements
- R1: When `start_i` is sampled with `bypass_i` high, `done_o` rises after exactly one clock edge. The outputs then equal the inputs, with digits above each length cleared.
- R2: While the fixed length and the periodic length are both nonzero and bit 0 of the fixed field equals bit 0 of the periodic field, one digit is absorbed per cycle. An absorb shifts the fixed field right by one, lowers the fixed length by one, and rotates the periodic field right by one within its length. Each absorb takes one cycle, and one further cycle ends the step.
- R3: A nonzero period of length n whose smallest repeating group has k digits is replaced by its leading k digits, with length k. This search takes k cycles.
- R4: A period whose digits are all zero leaves with length zero and field zero. This takes one cycle.
- R5: After leading normalization, the top digit of the fixed field (bit `fix_len_o-1`) is 1 whenever the fixed length is nonzero. When the fixed length is zero, the top digit of the period is 1. The exponent is lowered by one for each leading zero removed. A zero fixed digit is removed by shortening the fixed length. With an empty fixed part, a zero digit is removed by rotating the period left. Each removal takes one cycle, and the final check takes one more.
- R6: A normal run ends with `done_o` high exactly `a + s + z + 3` edges after the start edge. Here a is the number of absorbs, s is the period-search cycles (1 for an empty or all-zero period), and z is the number of leading zeros removed.
- R7: `done_o` is a one-cycle pulse. The outputs change only in the cycle in which `done_o` is high. A `start_i` pulse during a run is ignored.
- R8: A zero value, meaning both lengths end at zero, leaves with exponent zero.
- R9: Field bits at or above the given length are ignored. Output field bits at or above the output length are zero.
- R10: A fixed part `00` with the 20-digit period `00001010001111010111` and exponent 0 normalizes to an empty fixed part. The period becomes `10100011110101110000`, with length 20, and the exponent becomes -6 (0xFA).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; inputs are sampled on it while idle |
| bypass_i | input | 1 | Return the fields unchanged instead of normalizing |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | EXP_W | Exponent, two's complement |
| fix_i | input | FIX_W | Fixed digits, right-aligned |
| fix_len_i | input | clog2(FIX_W+1) | Fixed digit count |
| per_i | input | PER_W | Periodic digits, right-aligned |
| per_len_i | input | clog2(PER_W+1) | Periodic digit count |
| done_o | output | 1 | One-cycle completion pulse |
| sign_o | output | 1 | Result sign |
| exp_o | output | EXP_W | Result exponent |
| fix_o | output | FIX_W | Result fixed digits |
| fix_len_o | output | clog2(FIX_W+1) | Result fixed digit count |
| per_o | output | PER_W | Result periodic digits |
| per_len_o | output | clog2(PER_W+1) | Result periodic digit count |

## Verification
The assertions take for granted that `start_i` is a single-cycle pulse and is not raised in the same cycle that `done_o` is high. They also assume the input lengths never exceed their field widths, and that the exponent has enough headroom that lowering it cannot wrap.

The stimulus pulses `start_i` only from idle, except for one deliberate mid-run pulse. Lengths are drawn within their widths, and exponents start near the middle of their range. A behavioural bench model works on bit queues and predicts both the result and the exact cycle of `done_o`. Both are compared against the design on every clock.

// File: rtl/pmn_pkg.sv
package pmn_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ABSORB, ST_SUB, ST_LEAD} pmn_state_e;
endpackage

// File: rtl/pmn_rotl.sv
// Rotate a right-aligned digit string left by one within len_i digits.
module pmn_rotl #(
  parameter int W   = 24,
  parameter int L_W = 5
) (
  input  logic [W-1:0]   val_i,
  input  logic [L_W-1:0] len_i,
  output logic [W-1:0]   rot_o
);
  logic [W-1:0] mask;
  logic [W-1:0] top;

  assign mask  = ({{(W-1){1'b0}}, 1'b1} << len_i) - 1'b1;
  assign top   = val_i >> (len_i - 1'b1);
  assign rot_o = ((val_i << 1) & mask) | {{(W-1){1'b0}}, top[0]};
endmodule

// File: rtl/pmn_absorb.sv
module pmn_absorb #(
  parameter int FIX_W = 16,
  parameter int PER_W = 24,
  parameter int FL_W  = 5,
  parameter int PL_W  = 5
) (
  input  logic [FIX_W-1:0] fix_i,
  input  logic [FL_W-1:0]  fix_len_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PL_W-1:0]  per_len_i,
  output logic             hit_o,
  output logic [FIX_W-1:0] fix_o,
  output logic [FL_W-1:0]  fix_len_o,
  output logic [PER_W-1:0] per_o
);
  logic [PER_W-1:0] wrap;

  assign hit_o     = (fix_len_i != '0) && (per_len_i != '0) && (fix_i[0] == per_i[0]);
  assign wrap      = {{(PER_W-1){1'b0}}, per_i[0]} << (per_len_i - 1'b1);
  assign per_o     = (per_i >> 1) | wrap;
  assign fix_o     = fix_i >> 1;
  assign fix_len_o = fix_len_i - 1'b1;
endmodule

// File: rtl/pmn_subper.sv
module pmn_subper #(
  parameter int PER_W = 24,
  parameter int PL_W  = 5
) (
  input  logic [PER_W-1:0] cur_i,
  input  logic [PER_W-1:0] orig_i,
  input  logic [PL_W-1:0]  len_i,
  input  logic [PL_W-1:0]  k_i,
  output logic [PER_W-1:0] rot_o,
  output logic             match_o,
  output logic [PER_W-1:0] red_o
);
  pmn_rotl #(.W(PER_W), .L_W(PL_W)) u_rot (
    .val_i (cur_i),
    .len_i (len_i),
    .rot_o (rot_o)
  );

  assign match_o = (rot_o == orig_i);
  // leading k+1 digits of the unrotated period
  assign red_o   = orig_i >> (len_i - k_i - 1'b1);
endmodule

// File: rtl/pmn_lead.sv
module pmn_lead #(
  parameter int FIX_W = 16,
  parameter int PER_W = 24,
  parameter int FL_W  = 5,
  parameter int PL_W  = 5
) (
  input  logic [FIX_W-1:0] fix_i,
  input  logic [FL_W-1:0]  fix_len_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PL_W-1:0]  per_len_i,
  output logic             fin_o,
  output logic             zero_o,
  output logic [FL_W-1:0]  fix_len_o,
  output logic [PER_W-1:0] per_o
);
  logic [FIX_W-1:0] fix_top;
  logic [PER_W-1:0] per_top;
  logic [PER_W-1:0] per_rot;
  logic             fix_some;

  pmn_rotl #(.W(PER_W), .L_W(PL_W)) u_rot (
    .val_i (per_i),
    .len_i (per_len_i),
    .rot_o (per_rot)
  );

  assign fix_some  = (fix_len_i != '0);
  assign fix_top   = fix_i >> (fix_len_i - 1'b1);
  assign per_top   = per_i >> (per_len_i - 1'b1);
  assign zero_o    = !fix_some && (per_len_i == '0);
  assign fin_o     = fix_some ? fix_top[0] : (zero_o || per_top[0]);
  assign fix_len_o = fix_some ? fix_len_i - 1'b1 : fix_len_i;
  assign per_o     = fix_some ? per_i : per_rot;
endmodule

// File: rtl/pmn_top.sv
module pmn_top
  import pmn_pkg::*;
#(
  parameter int FIX_W = 16,
  parameter int PER_W = 24,
  parameter int EXP_W = 8,
  localparam int FL_W = $clog2(FIX_W + 1),
  localparam int PL_W = $clog2(PER_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bypass_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [FIX_W-1:0] fix_i,
  input  logic [FL_W-1:0]  fix_len_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PL_W-1:0]  per_len_i,
  output logic             done_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [FIX_W-1:0] fix_o,
  output logic [FL_W-1:0]  fix_len_o,
  output logic [PER_W-1:0] per_o,
  output logic [PL_W-1:0]  per_len_o
);
  pmn_state_e       state_q;
  logic             sign_q, byp_q, done_q;
  logic [EXP_W-1:0] exp_q;
  logic [FIX_W-1:0] fix_q;
  logic [FL_W-1:0]  fl_q;
  logic [PER_W-1:0] per_q, orig_q;
  logic [PL_W-1:0]  pl_q, k_q;

  logic             o_sign_q;
  logic [EXP_W-1:0] o_exp_q;
  logic [FIX_W-1:0] o_fix_q;
  logic [FL_W-1:0]  o_fl_q;
  logic [PER_W-1:0] o_per_q;
  logic [PL_W-1:0]  o_pl_q;

  logic [FIX_W-1:0] fix_in;
  logic [PER_W-1:0] per_in;

  assign fix_in = fix_i & (({{(FIX_W-1){1'b0}}, 1'b1} << fix_len_i) - 1'b1);
  assign per_in = per_i & (({{(PER_W-1){1'b0}}, 1'b1} << per_len_i) - 1'b1);

  logic             ab_hit;
  logic [FIX_W-1:0] ab_fix;
  logic [FL_W-1:0]  ab_fl;
  logic [PER_W-1:0] ab_per;

  pmn_absorb #(.FIX_W(FIX_W), .PER_W(PER_W), .FL_W(FL_W), .PL_W(PL_W)) u_absorb (
    .fix_i     (fix_q),
    .fix_len_i (fl_q),
    .per_i     (per_q),
    .per_len_i (pl_q),
    .hit_o     (ab_hit),
    .fix_o     (ab_fix),
    .fix_len_o (ab_fl),
    .per_o     (ab_per)
  );

  logic [PER_W-1:0] sp_rot, sp_red;
  logic             sp_match;

  pmn_subper #(.PER_W(PER_W), .PL_W(PL_W)) u_subper (
    .cur_i   (per_q),
    .orig_i  (orig_q),
    .len_i   (pl_q),
    .k_i     (k_q),
    .rot_o   (sp_rot),
    .match_o (sp_match),
    .red_o   (sp_red)
  );

  logic             ld_fin, ld_zero;
  logic [FL_W-1:0]  ld_fl;
  logic [PER_W-1:0] ld_per;

  pmn_lead #(.FIX_W(FIX_W), .PER_W(PER_W), .FL_W(FL_W), .PL_W(PL_W)) u_lead (
    .fix_i     (fix_q),
    .fix_len_i (fl_q),
    .per_i     (per_q),
    .per_len_i (pl_q),
    .fin_o     (ld_fin),
    .zero_o    (ld_zero),
    .fix_len_o (ld_fl),
    .per_o     (ld_per)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sign_q   <= 1'b0;
      byp_q    <= 1'b0;
      done_q   <= 1'b0;
      exp_q    <= '0;
      fix_q    <= '0;
      fl_q     <= '0;
      per_q    <= '0;
      orig_q   <= '0;
      pl_q     <= '0;
      k_q      <= '0;
      o_sign_q <= 1'b0;
      o_exp_q  <= '0;
      o_fix_q  <= '0;
      o_fl_q   <= '0;
      o_per_q  <= '0;
      o_pl_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            byp_q <= bypass_i;
            if (bypass_i) begin
              o_sign_q <= sign_i;
              o_exp_q  <= exp_i;
              o_fix_q  <= fix_in;
              o_fl_q   <= fix_len_i;
              o_per_q  <= per_in;
              o_pl_q   <= per_len_i;
              done_q   <= 1'b1;
            end else begin
              sign_q  <= sign_i;
              exp_q   <= exp_i;
              fix_q   <= fix_in;
              fl_q    <= fix_len_i;
              per_q   <= per_in;
              pl_q    <= per_len_i;
              state_q <= ST_ABSORB;
            end
          end
        end
        ST_ABSORB: begin
          if (ab_hit) begin
            fix_q <= ab_fix;
            fl_q  <= ab_fl;
            per_q <= ab_per;
          end else begin
            orig_q  <= per_q;
            k_q     <= '0;
            state_q <= ST_SUB;
          end
        end
        ST_SUB: begin
          if (pl_q == '0) begin
            state_q <= ST_LEAD;
          end else if (orig_q == '0) begin
            per_q   <= '0;
            pl_q    <= '0;
            state_q <= ST_LEAD;
          end else if (sp_match) begin
            per_q   <= sp_red;
            pl_q    <= k_q + 1'b1;
            state_q <= ST_LEAD;
          end else begin
            per_q <= sp_rot;
            k_q   <= k_q + 1'b1;
          end
        end
        ST_LEAD: begin
          if (ld_fin) begin
            o_sign_q <= sign_q;
            o_exp_q  <= ld_zero ? '0 : exp_q;
            o_fix_q  <= fix_q;
            o_fl_q   <= fl_q;
            o_per_q  <= per_q;
            o_pl_q   <= pl_q;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            fl_q  <= ld_fl;
            per_q <= ld_per;
            exp_q <= exp_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign sign_o    = o_sign_q;
  assign exp_o     = o_exp_q;
  assign fix_o     = o_fix_q;
  assign fix_len_o = o_fl_q;
  assign per_o     = o_per_q;
  assign per_len_o = o_pl_q;

  logic [FIX_W-1:0] chk_ftop;
  logic [PER_W-1:0] chk_ptop;
  assign chk_ftop = fix_o >> (fix_len_o - 1'b1);
  assign chk_ptop = per_o >> (per_len_o - 1'b1);

  p_absorb_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !byp_q && fix_len_o != '0 && per_len_o != '0) |-> (fix_o[0] != per_o[0]));

  p_sub_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUB) |-> (pl_q == '0 || k_q < pl_q));

  p_period_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !byp_q && per_len_o != '0) |-> (per_o != '0));

  p_lead_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !byp_q && fix_len_o != '0) |-> chk_ftop[0]);

  p_lead_per_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !byp_q && fix_len_o == '0 && per_len_o != '0) |-> chk_ptop[0]);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_out_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(fix_o) && $stable(per_o) && $stable(exp_o) && $stable(fix_len_o)));

  p_zero_exp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !byp_q && fix_len_o == '0 && per_len_o == '0) |-> (exp_o == '0));

  p_fix_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((fix_o >> fix_len_o) == '0));
endmodule

// File: tb/pmn_top_bench.sv
module pmn_top_bench;
  localparam int FIX_W = 16;
  localparam int PER_W = 24;
  localparam int EXP_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             bypass_i = 1'b0;
  logic             sign_i = 1'b0;
  logic [EXP_W-1:0] exp_i = '0;
  logic [FIX_W-1:0] fix_i = '0;
  logic [4:0]       fix_len_i = '0;
  logic [PER_W-1:0] per_i = '0;
  logic [4:0]       per_len_i = '0;
  logic             done_o, sign_o;
  logic [EXP_W-1:0] exp_o;
  logic [FIX_W-1:0] fix_o;
  logic [4:0]       fix_len_o;
  logic [PER_W-1:0] per_o;
  logic [4:0]       per_len_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  pmn_top #(.FIX_W(FIX_W), .PER_W(PER_W), .EXP_W(EXP_W)) u_pmn_top (
    .clk_i, .rst_ni, .start_i, .bypass_i, .sign_i, .exp_i, .fix_i, .fix_len_i,
    .per_i, .per_len_i, .done_o, .sign_o, .exp_o, .fix_o, .fix_len_o, .per_o, .per_len_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // behavioural model on bit queues, most significant digit first
  task automatic model(input logic [FIX_W-1:0] f, input int fl, input logic [PER_W-1:0] p,
                       input int pl, input logic [EXP_W-1:0] e,
                       output logic [FIX_W-1:0] fo, output int flo, output logic [PER_W-1:0] po,
                       output int plo, output logic [EXP_W-1:0] eo, output int lat);
    bit fq[$];
    bit pq[$];
    bit b;
    int a = 0, s = 1, z = 0, ev, n;
    ev = int'(e);
    for (int i = fl - 1; i >= 0; i--) fq.push_back(f[i]);
    for (int i = pl - 1; i >= 0; i--) pq.push_back(p[i]);
    while (fq.size() > 0 && pq.size() > 0 && fq[fq.size()-1] == pq[pq.size()-1]) begin
      void'(fq.pop_back());
      b = pq.pop_back();
      pq.push_front(b);
      a++;
    end
    n = pq.size();
    if (n > 0) begin
      bit allz = 1;
      foreach (pq[i]) if (pq[i]) allz = 0;
      if (allz) pq.delete();
      else begin
        for (int k = 1; k <= n; k++) begin
          bit same = 1;
          for (int i = 0; i < n; i++) if (pq[i] != pq[(i + k) % n]) same = 0;
          if (same) begin s = k; break; end
        end
        while (pq.size() > s) void'(pq.pop_back());
      end
    end
    forever begin
      if (fq.size() > 0) begin
        if (fq[0]) break;
        void'(fq.pop_front());
        ev--; z++;
      end else if (pq.size() == 0) begin
        ev = 0; break;
      end else begin
        if (pq[0]) break;
        b = pq.pop_front();
        pq.push_back(b);
        ev--; z++;
      end
    end
    fo = '0; po = '0;
    foreach (fq[i]) fo = (fo << 1) | FIX_W'(fq[i]);
    foreach (pq[i]) po = (po << 1) | PER_W'(pq[i]);
    flo = fq.size(); plo = pq.size();
    eo = EXP_W'(ev);
    lat = a + s + z + 3;
  endtask

  task automatic run_case(bit byp, logic sg, logic [EXP_W-1:0] e, logic [FIX_W-1:0] f, int fl,
                          logic [PER_W-1:0] p, int pl, string req, bit inject);
    logic [FIX_W-1:0] xf, fm;
    logic [PER_W-1:0] xp, pm;
    logic [EXP_W-1:0] xe;
    int xfl, xpl, lat;
    bit tim_ok = 1;
    int first_bad = 0;
    fm = f & FIX_W'((64'd1 << fl) - 1);
    pm = p & PER_W'((64'd1 << pl) - 1);
    if (byp) begin
      xf = fm; xfl = fl; xp = pm; xpl = pl; xe = e; lat = 1;
    end else model(f, fl, p, pl, e, xf, xfl, xp, xpl, xe, lat);
    @(negedge clk_i);
    bypass_i = byp; sign_i = sg; exp_i = e; fix_i = f; fix_len_i = 5'(fl);
    per_i = p; per_len_i = 5'(pl); start_i = 1'b1;
    @(posedge clk_i);
    for (int c = 1; c <= lat + 1; c++) begin
      if (c > 1) @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      if (inject && c == 2 && lat > 3) begin
        start_i = 1'b1; bypass_i = 1'b1; fix_i = ~f; exp_i = ~e;
      end
      if (done_o !== (c == lat) && tim_ok) begin tim_ok = 0; first_bad = c; end
    end
    start_i = 1'b0;
    chk(tim_ok, (byp ? "R1" : "R6"), "done timing", first_bad, lat);
    chk(exp_o == xe && sign_o == sg, req, "exp", exp_o, xe);
    chk(fix_o == xf && int'(fix_len_o) == xfl, req, "fix", {fix_len_o, fix_o}, {5'(xfl), xf});
    chk(per_o == xp && int'(per_len_o) == xpl, req, "per", {per_len_o, per_o}, {5'(xpl), xp});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state
    chk(done_o == 0 && fix_len_o == 0 && per_len_o == 0 && exp_o == 0, "R7", "reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 0, "R7", "idle done", done_o, 0);

    run_case(1, 1, 8'h12, 16'hF0A5, 7, 24'hFFFFFF, 5, "R1", 0);     // R1 bypass, R9 masking
    run_case(0, 0, 8'h40, 16'h0005, 3, 24'h000001, 2, "R2", 0);     // R2 full absorb
    run_case(0, 0, 8'h40, 16'h0002, 2, 24'h00001B, 6, "R3", 0);     // R3 011011 -> 011
    run_case(0, 1, 8'h40, 16'h0001, 1, 24'h000000, 4, "R4", 0);     // R4 zero period
    run_case(0, 0, 8'h40, 16'h0001, 4, 24'h000002, 2, "R5", 0);     // R5 leading zeros
    run_case(0, 0, 8'h40, 16'h0000, 2, 24'h000005, 4, "R5", 0);     // R5 rotate period
    run_case(0, 0, 8'h22, 16'h0000, 3, 24'h000000, 0, "R8", 0);     // R8 zero value
    run_case(0, 0, 8'h00, 16'h0000, 2, 24'h0A3D7, 20, "R10", 0);    // R10 one hundredth
    chk(per_o == 24'hA3D70 && exp_o == 8'hFA && fix_len_o == 0, "R10", "literal", per_o, 24'hA3D70);
    run_case(0, 0, 8'h40, 16'hFFE0, 5, 24'hFFFF00, 6, "R9", 0);     // R9 junk above lengths
    run_case(0, 0, 8'h40, 16'h0002, 2, 24'h00001B, 6, "R7", 1);     // R7 start ignored while busy
    run_case(0, 0, 8'h40, 16'hFFFF, 16, 24'hFFFFFF, 24, "R2", 0);   // R2 absorb to empty
    run_case(0, 0, 8'h40, 16'h0000, 0, 24'h249249, 24, "R3", 0);    // R3 full-width period

    for (int t = 0; t < 300; t++) begin
      int fl = $urandom_range(0, FIX_W);
      int pl;
      logic [PER_W-1:0] p;
      if ($urandom_range(0, 1) == 1) begin
        int k = $urandom_range(1, 6);
        int r = $urandom_range(1, PER_W / k);
        logic [5:0] pat = 6'($urandom);
        p = '0;
        for (int i = 0; i < k * r; i++) p[i] = pat[i % k];
        pl = k * r;
      end else begin
        pl = $urandom_range(0, PER_W);
        p = PER_W'($urandom);
      end
      run_case(0, 1'($urandom), 8'h50, 16'($urandom), fl, p, pl, "R6", t % 37 == 0);
    end
    summary();
  end
endmodule